// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of an event timer. It holds a configuration word, a comparator, a period value and a message word. It watches a shared free-running counter, and when the counter steps onto the comparator value it raises an interrupt in one of three forms. The first is a one-cycle pulse on a routed line. The second is a level that is held by a status bit until it is cleared. The third is a message of address and data. The register accesses arrive already decoded as separate write strobes with byte-lane-style bit masks. Reads are plain continuous outputs.

In one-shot mode the comparator is loaded directly from writes. In periodic mode a comparator write sets the period. The comparator itself is only reloaded when a self-clearing "load value" bit is set. After each match the comparator moves on by one period.

Control is a two-state machine. In ST_ARMED the channel compares the counter against the comparator. The transition *hit* (a counter step equal to the comparator) moves to ST_FIRE and latches the delivery kind. ST_FIRE drives the pulse or message for one cycle and performs the periodic reload. It then takes the unconditional transition *rearm* back to ST_ARMED.

Top module: `timer_chan`

## Requirements
- R1: After reset the comparator reads 0xFFFFFFFF, the message word reads 0, all interrupt outputs are low, and the configuration reads its allowed-line mask in bits 63:32, with bit 4 (periodic capable) and bit 15 (message capable) set and every other bit clear.
- R2: A configuration write updates only the writable bits: 1 (level type), 2 (interrupt enable), 3 (periodic), 6 (load value), 13:9 (route) and 14 (message enable). Bits 63:32, 15, 5 and 4 keep their values. Bit 8 and all other bits always read 0.
- R3: If a written route is nonzero and its bit is clear in the allowed-line mask, the route field is stored as 0.
- R4: With bit 3 clear (one-shot), a comparator write loads the comparator directly, and a match leaves the comparator unchanged.
- R5: With bit 3 set (periodic), a comparator write sets the period, and loads the comparator only when bit 6 is 1. Bit 6 reads 0 after any comparator write.
- R6: A match occurs only on a cycle where `cnt_tick` is high and `cnt_val` equals the comparator. The interrupt outputs respond in the cycle after that clock edge.
- R7: In periodic mode the comparator increases by the period in the cycle after a match.
- R8: A match produces no pulse, level or message when bit 2 is 0, or when messages are off and the route is 0.
- R9: With a nonzero route and bit 1 clear, a match gives a single-cycle `irq_pulse`, and `irq_line` shows the route.
- R10: With a nonzero route and bit 1 set, a match sets `irq_level`. A further match while it is set changes nothing. `sts_clr` clears it.
- R11: A set `irq_level` clears on a configuration write that disables interrupts, selects edge type, enables messages or changes the route. A write that does none of these leaves it set.
- R12: With bits 15 and 14 both set, a match gives a single-cycle `msg_valid`, with `msg_addr` taken from message bits 63:32 and `msg_data` from bits 31:0. Message writes honour the bit mask.
- R13: The allowed-line mask is 0xFF000000 for 32 or more controller inputs, the top four lines below the input count for 20 to 31 inputs, and 0 otherwise. The default of 24 inputs gives 0x00F00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Shared main counter value |
| cnt_tick | input | 1 | Counter advanced to `cnt_val` this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wmask | input | 64 | Configuration bits to update |
| cfg_wdata | input | 64 | Configuration write data |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | CNT_W | Comparator write data |
| msg_we | input | 1 | Message word write strobe |
| msg_wmask | input | 64 | Message bits to update |
| msg_wdata | input | 64 | Message write data |
| sts_clr | input | 1 | Clear level status |
| cfg_rdata | output | 64 | Configuration readback |
| cmp_rdata | output | CNT_W | Comparator readback |
| msg_rdata | output | 64 | Message word readback |
| irq_line | output | 5 | Selected interrupt line |
| irq_pulse | output | 1 | Edge interrupt pulse |
| irq_level | output | 1 | Level interrupt and its status bit |
| msg_valid | output | 1 | Message delivery strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
A comparator or period that is off by even one step shows up at the next match. The pulse or message appears at the wrong counter value, and the comparator readback differs one cycle after the match. A stale delivery kind or status bit shows up in the cycle right after the matching edge: a pulse where a level was due, a level that survives a route change, or a repeat match that re-fires. Configuration sanitising errors are visible on the very next readback, before any match takes place.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

    localparam int B_LVL  = 1;
    localparam int B_IEN  = 2;
    localparam int B_PER  = 3;
    localparam int B_PCAP = 4;
    localparam int B_VSET = 6;
    localparam int B_RTLO = 9;
    localparam int B_RTHI = 13;
    localparam int B_MEN  = 14;
    localparam int B_MCAP = 15;

    // writable: 1,2,3,6,13:9,14 ; read-only: 63:32,15,5,4
    localparam logic [63:0] CFG_WR = 64'h0000_0000_0000_7E4E;
    localparam logic [63:0] CFG_RO = 64'hFFFF_FFFF_0000_8030;

    typedef enum logic [0:0] {ST_ARMED, ST_FIRE} chan_state_e;
    typedef enum logic [1:0] {DLV_NONE, DLV_EDGE, DLV_LEVEL, DLV_MSG} dlv_kind_e;

    function automatic logic [31:0] line_mask(input int n);
        if (n >= 32)      return 32'hFF00_0000;
        else if (n >= 20) return 32'hF << (n - 4);
        else              return 32'h0;
    endfunction

endpackage

// File: rtl/timer_chan_cfg.sv
module timer_chan_cfg
    import timer_chan_pkg::*;
#(
    parameter int CTRL_INPUTS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [63:0] cfg_wmask,
    input  logic [63:0] cfg_wdata,
    input  logic        cmp_we,
    output logic [63:0] cfg_q,
    output logic        cfg_drop
);
    localparam logic [31:0] ALLOW   = line_mask(CTRL_INPUTS);
    localparam logic [63:0] CFG_RST = {ALLOW, 32'h0} | (64'h1 << B_PCAP) | (64'h1 << B_MCAP);

    logic [63:0] merged;
    logic [63:0] cfg_next;
    logic [4:0]  rt_new;

    always_comb begin
        merged   = (cfg_q & ~cfg_wmask) | (cfg_wdata & cfg_wmask);
        cfg_next = (merged & CFG_WR) | (cfg_q & CFG_RO);
        rt_new   = cfg_next[B_RTHI:B_RTLO];
        if (rt_new != 5'd0 && !ALLOW[rt_new])
            cfg_next[B_RTHI:B_RTLO] = 5'd0;
    end

    // level status must drop when the new setting can no longer hold it
    assign cfg_drop = cfg_we &&
        (!cfg_next[B_IEN] || (cfg_next[B_MCAP] && cfg_next[B_MEN]) || !cfg_next[B_LVL] ||
         (cfg_next[B_RTHI:B_RTLO] != cfg_q[B_RTHI:B_RTLO]));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_next;
            if (cmp_we)
                cfg_q[B_VSET] <= 1'b0;
        end
    end

    p_route_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[B_RTHI:B_RTLO] != 5'd0) |-> ALLOW[cfg_q[B_RTHI:B_RTLO]]);

    p_vset_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !cfg_q[B_VSET]);

endmodule

// File: rtl/timer_chan_cmp.sv
module timer_chan_cmp #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             periodic,
    input  logic             vset,
    input  logic             reload,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match
);
    logic [CNT_W-1:0] per_q;

    assign match = cnt_tick && (cnt_val == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (cmp_we && periodic) begin
            per_q <= cmp_wdata;
        end else if (!periodic) begin
            per_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_we && (!periodic || vset)) begin
            cmp_q <= cmp_wdata;
        end else if (reload && periodic && !cmp_we) begin
            cmp_q <= cmp_q + per_q;
        end
    end

    p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && !cmp_we) |=> $stable(cmp_q));

    p_reload_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && periodic && !cmp_we) |=> (cmp_q == $past(cmp_q) + $past(per_q)));

endmodule

// File: rtl/timer_chan_dlv.sv
module timer_chan_dlv
    import timer_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic ien,
    input  logic lvl,
    input  logic msg_on,
    input  logic route_nz,
    input  logic cfg_drop,
    input  logic sts_clr,
    output logic reload,
    output logic irq_pulse,
    output logic irq_level,
    output logic msg_valid
);
    chan_state_e state_q, state_d;
    dlv_kind_e   kind_q, kind_d;
    logic        sts_q;
    logic        hit;

    assign hit = match && (state_q == ST_ARMED);

    always_comb begin
        if (!ien)           kind_d = DLV_NONE;
        else if (sts_q)     kind_d = DLV_NONE;
        else if (msg_on)    kind_d = DLV_MSG;
        else if (!route_nz) kind_d = DLV_NONE;
        else if (!lvl)      kind_d = DLV_EDGE;
        else                kind_d = DLV_LEVEL;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (hit) state_d = ST_FIRE;
            ST_FIRE:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            kind_q  <= DLV_NONE;
            sts_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (hit)
                kind_q <= kind_d;
            if (hit && kind_d == DLV_LEVEL)
                sts_q <= 1'b1;
            else if (sts_clr || cfg_drop)
                sts_q <= 1'b0;
        end
    end

    always_comb begin
        reload    = 1'b0;
        irq_pulse = 1'b0;
        msg_valid = 1'b0;
        unique case (state_q)
            ST_ARMED: ;
            ST_FIRE: begin
                reload    = 1'b1;
                irq_pulse = (kind_q == DLV_EDGE);
                msg_valid = (kind_q == DLV_MSG);
            end
        endcase
    end
    assign irq_level = sts_q;

    p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    p_msg_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    p_one_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pulse && msg_valid));

    p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level && !sts_clr && !cfg_drop) |=> irq_level);

endmodule

// File: rtl/timer_chan.sv
module timer_chan
    import timer_chan_pkg::*;
#(
    parameter int CTRL_INPUTS = 24,
    parameter int CNT_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic             cfg_we,
    input  logic [63:0]      cfg_wmask,
    input  logic [63:0]      cfg_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             msg_we,
    input  logic [63:0]      msg_wmask,
    input  logic [63:0]      msg_wdata,
    input  logic             sts_clr,
    output logic [63:0]      cfg_rdata,
    output logic [CNT_W-1:0] cmp_rdata,
    output logic [63:0]      msg_rdata,
    output logic [4:0]       irq_line,
    output logic             irq_pulse,
    output logic             irq_level,
    output logic             msg_valid,
    output logic [31:0]      msg_addr,
    output logic [31:0]      msg_data
);
    logic [63:0]      cfg_q;
    logic             cfg_drop;
    logic [CNT_W-1:0] cmp_q;
    logic             match;
    logic             reload;
    logic [63:0]      msg_q;

    timer_chan_cfg #(.CTRL_INPUTS(CTRL_INPUTS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wmask(cfg_wmask),
        .cfg_wdata(cfg_wdata),
        .cmp_we   (cmp_we),
        .cfg_q    (cfg_q),
        .cfg_drop (cfg_drop)
    );

    timer_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cnt_tick (cnt_tick),
        .cmp_we   (cmp_we),
        .cmp_wdata(cmp_wdata),
        .periodic (cfg_q[B_PER]),
        .vset     (cfg_q[B_VSET]),
        .reload   (reload),
        .cmp_q    (cmp_q),
        .match    (match)
    );

    timer_chan_dlv u_dlv (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .ien      (cfg_q[B_IEN]),
        .lvl      (cfg_q[B_LVL]),
        .msg_on   (cfg_q[B_MCAP] && cfg_q[B_MEN]),
        .route_nz (cfg_q[B_RTHI:B_RTLO] != 5'd0),
        .cfg_drop (cfg_drop),
        .sts_clr  (sts_clr),
        .reload   (reload),
        .irq_pulse(irq_pulse),
        .irq_level(irq_level),
        .msg_valid(msg_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_q <= '0;
        else if (msg_we)
            msg_q <= (msg_q & ~msg_wmask) | (msg_wdata & msg_wmask);
    end

    assign cfg_rdata = cfg_q;
    assign cmp_rdata = cmp_q;
    assign msg_rdata = msg_q;
    assign irq_line  = cfg_q[B_RTHI:B_RTLO];
    assign msg_addr  = msg_q[63:32];
    assign msg_data  = msg_q[31:0];

endmodule

// File: tb/tb_timer_chan.sv
`timescale 1ns/1ps
module tb_timer_chan;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cnt_val;
    logic        cnt_tick;
    logic        cfg_we;
    logic [63:0] cfg_wmask, cfg_wdata;
    logic        cmp_we;
    logic [31:0] cmp_wdata;
    logic        msg_we;
    logic [63:0] msg_wmask, msg_wdata;
    logic        sts_clr;
    logic [63:0] cfg_rdata, msg_rdata;
    logic [31:0] cmp_rdata, msg_addr, msg_data;
    logic [4:0]  irq_line;
    logic        irq_pulse, irq_level, msg_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [63:0] UPPER = 64'h00F0_0000_0000_0000;

    always #5 clk = ~clk;

    timer_chan dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .cfg_we(cfg_we), .cfg_wmask(cfg_wmask), .cfg_wdata(cfg_wdata),
        .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .msg_we(msg_we), .msg_wmask(msg_wmask), .msg_wdata(msg_wdata),
        .sts_clr(sts_clr), .cfg_rdata(cfg_rdata), .cmp_rdata(cmp_rdata),
        .msg_rdata(msg_rdata), .irq_line(irq_line), .irq_pulse(irq_pulse),
        .irq_level(irq_level), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [63:0] d);
        cfg_wdata = d; cfg_wmask = '1; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] d);
        cmp_wdata = d; cmp_we = 1'b1;
        @(negedge clk); cmp_we = 1'b0;
    endtask

    task automatic wr_msg(input logic [63:0] m, input logic [63:0] d);
        msg_wmask = m; msg_wdata = d; msg_we = 1'b1;
        @(negedge clk); msg_we = 1'b0;
    endtask

    // one counter step; returns at the negedge after the matching edge
    task automatic tick(input logic [31:0] v);
        cnt_val = v; cnt_tick = 1'b1;
        @(negedge clk); cnt_tick = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 cfg reset", cfg_rdata, UPPER | 64'h8010);
        chk("R13 allowed mask", {32'h0, cfg_rdata[63:32]}, 64'h00F0_0000);
        chk("R1 cmp reset", {32'h0, cmp_rdata}, 64'hFFFF_FFFF);
        chk("R1 msg reset", msg_rdata, 64'h0);
        chk("R1 outputs idle", {61'h0, irq_pulse, irq_level, msg_valid}, 64'h0);
    endtask

    task automatic t_cfg_fields;
        wr_cfg('1);
        chk("R2 R3 all-ones write", cfg_rdata, UPPER | 64'hC05E);
        wr_cfg(64'h0);
        chk("R2 read-only kept", cfg_rdata, UPPER | 64'h8010);
        wr_cfg(64'h0A04);
        chk("R3 illegal route 5", cfg_rdata, UPPER | 64'h8014);
        wr_cfg(64'h2C04);
        chk("R3 legal route 22", cfg_rdata, UPPER | 64'hAC14);
    endtask

    task automatic t_oneshot_edge;
        wr_cmp(32'd100);
        chk("R4 one-shot load", {32'h0, cmp_rdata}, 64'd100);
        cnt_val = 32'd100; cnt_tick = 1'b0;
        @(negedge clk);
        chk("R6 no tick no match", {63'h0, irq_pulse}, 64'h0);
        tick(32'd99);
        chk("R6 unequal no pulse", {63'h0, irq_pulse}, 64'h0);
        tick(32'd100);
        chk("R9 edge pulse", {63'h0, irq_pulse}, 64'h1);
        chk("R9 line shown", {59'h0, irq_line}, 64'd22);
        chk("R10 edge no level", {63'h0, irq_level}, 64'h0);
        @(negedge clk);
        chk("R9 pulse one cycle", {63'h0, irq_pulse}, 64'h0);
        chk("R4 one-shot no reload", {32'h0, cmp_rdata}, 64'd100);
    endtask

    task automatic t_periodic;
        wr_cfg(64'h2C4C);
        chk("R5 load bit set", cfg_rdata, UPPER | 64'hAC5C);
        wr_cmp(32'd200);
        chk("R5 cmp loaded", {32'h0, cmp_rdata}, 64'd200);
        chk("R5 load bit cleared", cfg_rdata, UPPER | 64'hAC1C);
        wr_cmp(32'd50);
        chk("R5 cmp kept", {32'h0, cmp_rdata}, 64'd200);
        tick(32'd200);
        chk("R9 periodic pulse", {63'h0, irq_pulse}, 64'h1);
        @(negedge clk);
        chk("R7 reload by period", {32'h0, cmp_rdata}, 64'd250);
        tick(32'd250);
        chk("R7 second match", {63'h0, irq_pulse}, 64'h1);
        @(negedge clk);
        chk("R7 second reload", {32'h0, cmp_rdata}, 64'd300);
    endtask

    task automatic t_silent;
        wr_cfg(64'h2C00);
        wr_cmp(32'd400);
        tick(32'd400);
        chk("R8 disabled silent", {61'h0, irq_pulse, irq_level, msg_valid}, 64'h0);
        @(negedge clk);
        wr_cfg(64'h0004);
        tick(32'd400);
        chk("R8 route zero silent", {61'h0, irq_pulse, irq_level, msg_valid}, 64'h0);
        @(negedge clk);
    endtask

    task automatic t_level;
        wr_cfg(64'h2C06);
        wr_cmp(32'd500);
        tick(32'd500);
        chk("R10 level set", {62'h0, irq_level, irq_pulse}, 64'h2);
        @(negedge clk);
        tick(32'd500);
        chk("R10 repeat ignored", {62'h0, irq_level, irq_pulse}, 64'h2);
        @(negedge clk);
        sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
        chk("R10 status cleared", {63'h0, irq_level}, 64'h0);
    endtask

    task automatic t_autoclear;
        tick(32'd500); @(negedge clk);
        wr_cfg(64'h2C06);
        chk("R11 same cfg keeps", {63'h0, irq_level}, 64'h1);
        wr_cfg(64'h2E06);
        chk("R11 route change clears", {63'h0, irq_level}, 64'h0);
        tick(32'd500); @(negedge clk);
        chk("R10 level on new line", {58'h0, irq_level, irq_line}, {58'h0, 1'b1, 5'd23});
        wr_cfg(64'h2E04);
        chk("R11 edge type clears", {63'h0, irq_level}, 64'h0);
        wr_cfg(64'h2E06);
        tick(32'd500); @(negedge clk);
        wr_cfg(64'h2E02);
        chk("R11 disable clears", {63'h0, irq_level}, 64'h0);
    endtask

    task automatic t_message;
        wr_msg('1, 64'h0000_FEE0_0000_0041);
        chk("R12 msg write", msg_rdata, 64'h0000_FEE0_0000_0041);
        wr_cfg(64'h4004);
        chk("R2 msg enable", cfg_rdata, UPPER | 64'hC014);
        wr_cmp(32'd600);
        tick(32'd600);
        chk("R12 msg strobe", {63'h0, msg_valid}, 64'h1);
        chk("R12 msg payload", {msg_addr, msg_data}, 64'h0000_FEE0_0000_0041);
        chk("R12 no pulse", {63'h0, irq_pulse}, 64'h0);
        @(negedge clk);
        chk("R12 strobe one cycle", {63'h0, msg_valid}, 64'h0);
        wr_msg(64'hFFFF_FFFF_0000_0000, 64'h1234_5678_9999_9999);
        chk("R12 masked write", msg_rdata, 64'h1234_5678_0000_0041);
    endtask

    initial begin
        rst_n = 1'b0; cnt_val = '0; cnt_tick = 1'b0;
        cfg_we = 1'b0; cfg_wmask = '0; cfg_wdata = '0;
        cmp_we = 1'b0; cmp_wdata = '0;
        msg_we = 1'b0; msg_wmask = '0; msg_wdata = '0; sts_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_fields();
        t_oneshot_edge();
        t_periodic();
        t_silent();
        t_level();
        t_autoclear();
        t_message();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule